// File: doc/BRIEF.md
# Single-Wire Manchester Bit Engine

This block is the bit-level half of a master for a serial bus where clock and data travel together on one pulled-up, open-drain line. Each bit is a mid-bit transition: the direction of the edge carries the value. Given one request, the engine moves a single byte most significant bit first. For a write it drives the byte onto the line. For a read it releases the line and decodes the byte from the slave. In both cases it then drives its own acknowledge symbol and finally releases the line to check the slave's acknowledge.

An upstream sequencer builds whole frames (header, start byte, addresses, data) out of single-byte requests. For every byte it chooses the direction, whether more bytes follow (acknowledge or no-acknowledge from the master), and which slave reply to expect. The time unit is a quarter-bit measured in system clocks. This value is set at run time, so one netlist covers bit rates from about 10 to 100 kbit/s. At the end of each request the engine reports a done strobe, an error flag and, after a clean read, the received byte.

Top module: `swire_bit_engine`

## Requirements
- R1: On a write, every data bit is driven (`lineOe`=1) as two half-bits of two quarters each: a 1 is low then high, a 0 is high then low.
- R2: A byte is sent as eight bits, most significant bit first, each bit lasting four effective quarters, starting at the clock edge that accepts the request.
- R3: On a read the line is released during the eight data bits. Each bit is sampled at its one-quarter and three-quarter points: low then high gives 1, high then low gives 0. `rxByte` (MSB received first) changes only when a read completes without error and otherwise keeps its value.
- R4: On a read, two equal samples in one bit abort the request at that bit's three-quarter point with `done` and `err`, and the line is released.
- R5: After the eight data bits of either direction, the engine drives one acknowledge bit: `moreBytes`=1 gives low then high, `moreBytes`=0 gives high then low.
- R6: With `noSak`=0 the engine releases the line and polls it once per quarter, up to 20 polls. If low is first seen at poll d (0-based), completion comes 4 quarters later, i.e. (41+d) quarters after acceptance. If no low is seen in 20 polls, the request ends with `err` 56 quarters after acceptance.
- R7: With `noSak`=0, if the line is not high at the end of the four quarters after the low was seen, the request ends with `err`.
- R8: With `noSak`=1 the engine polls in the same way for a high level, with the same 20-poll limit and the same completion and timeout times; it never checks the level again after that.
- R9: The effective quarter is `quarterTicks`, raised to 4 when smaller. It is captured when a request is accepted, and later changes to `quarterTicks` have no effect on that request.
- R10: `done` is a one-cycle pulse at the end of every request. `err` is cleared when a request is accepted, is only set together with `done`, and then holds until the next acceptance.
- R11: While idle the line is released. A request presented while busy is ignored.
- R12: After reset the line is released and `busy`, `done`, `err` and `rxByte` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| quarterTicks | input | 16 | Quarter-bit length in system clocks (values below 4 act as 4) |
| opValid | input | 1 | Request strobe, accepted when idle |
| opRead | input | 1 | 1 = receive a byte, 0 = transmit `txByte` |
| moreBytes | input | 1 | 1 = send master acknowledge, 0 = send master no-acknowledge |
| noSak | input | 1 | 1 = expect the line to return high, 0 = expect the slave acknowledge |
| txByte | input | 8 | Byte to transmit |
| lineIn | input | 1 | Level seen on the shared pulled-up line |
| lineOe | output | 1 | 1 = the engine drives the line |
| lineOut | output | 1 | Level driven while `lineOe` is 1 |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request strobe |
| err | output | 1 | Outcome of the last request (1 = failed) |
| rxByte | output | 8 | Last byte received without error |

## Verification
Two events can fall on the same quarter tick: detecting the slave's low reply, and expiring the poll limit. The bench has the slave pull the line exactly at the twentieth poll. It expects completion without error at (41+19) quarters, not a timeout at 56. A second collision is a new request that arrives while the engine is still shifting: the bench raises the request strobe with an inverted byte, and also changes the quarter length, in the middle of a write. It then checks that the bits captured from the line and the completion cycle still match the original request.

// File: rtl/swire_pkg.sv
package swire_pkg;

  // Phases of one byte request
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DATA,
    PH_ACKOUT,
    PH_ACKWAIT,
    PH_ACKHOLD
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;       // request accepted: load byte, quarter length, clear counters
    logic run;         // quarter timer runs
    logic clrQuarter;  // restart quarter index (slave reply found)
    logic takeFirst;   // capture first-quarter sample
    logic takeBit;     // decode bit from both samples
    logic bitEnd;      // end of a data bit: advance shift and bit index
    logic pollInc;     // one more unsuccessful poll
    logic commitRx;    // publish received byte
    logic driveOn;     // engine owns the line
    logic useAckSym;   // drive the acknowledge symbol instead of data
    logic ackSym;      // acknowledge symbol value (1 = low then high)
  } dpCtrl_t;

  // Status from datapath to control
  typedef struct packed {
    logic       qTick;
    logic [1:0] qIdx;
    logic       lastBit;
    logic       pollLast;
    logic       firstSample;
    logic       lineNow;
  } dpStat_t;

endpackage

// File: rtl/swire_datapath.sv
module swire_datapath
  import swire_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int QUARTER_W   = 16,
  parameter int MIN_QUARTER = 4,
  parameter int POLL_LIMIT  = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [QUARTER_W-1:0] quarterTicks,
  input  logic [DATA_BITS-1:0] txByte,
  input  dpCtrl_t              ctl,
  input  logic                 lineIn,
  output dpStat_t              stat,
  output logic                 lineOe,
  output logic                 lineOut,
  output logic [DATA_BITS-1:0] rxByte
);

  localparam int BIT_W  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int POLL_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [QUARTER_W-1:0] Q_FLOOR = QUARTER_W'(MIN_QUARTER);

  logic [QUARTER_W-1:0] qLen;
  logic [QUARTER_W-1:0] qCnt;
  logic [1:0]           qIdx;
  logic [BIT_W-1:0]     bitIdx;
  logic [POLL_W-1:0]    pollCnt;
  logic [DATA_BITS-1:0] txShift;
  logic [DATA_BITS-1:0] rxShift;
  logic                 firstSample;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                 lineNow;
  logic                 qTick;
  logic                 symBit;

  // Input synchronizer, depth chosen by parameter
  generate
    if (SYNC_STAGES > 1) begin : g_syncChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
      end
    end else begin : g_syncSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= lineIn;
      end
    end
  endgenerate

  assign lineNow = syncQ[SYNC_STAGES-1];

  // Quarter-bit timer
  assign qTick = ctl.run && (qCnt == qLen - QUARTER_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qLen <= Q_FLOOR;
      qCnt <= '0;
      qIdx <= '0;
    end else begin
      if (ctl.start) begin
        qLen <= (quarterTicks < Q_FLOOR) ? Q_FLOOR : quarterTicks;
        qCnt <= '0;
        qIdx <= '0;
      end else if (ctl.run) begin
        qCnt <= qTick ? '0 : qCnt + QUARTER_W'(1);
        if (ctl.clrQuarter)  qIdx <= '0;
        else if (qTick)      qIdx <= qIdx + 2'd1;
      end
    end
  end

  // Bit and poll counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx  <= '0;
      pollCnt <= '0;
    end else if (ctl.start) begin
      bitIdx  <= '0;
      pollCnt <= '0;
    end else begin
      if (ctl.bitEnd)  bitIdx  <= bitIdx + BIT_W'(1);
      if (ctl.pollInc) pollCnt <= pollCnt + POLL_W'(1);
    end
  end

  // Shift registers and sampling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift     <= '0;
      rxShift     <= '0;
      firstSample <= 1'b1;
      rxByte      <= '0;
    end else begin
      if (ctl.start)          txShift <= txByte;
      else if (ctl.bitEnd)    txShift <= {txShift[DATA_BITS-2:0], 1'b0};
      if (ctl.takeFirst)      firstSample <= lineNow;
      if (ctl.takeBit)        rxShift <= {rxShift[DATA_BITS-2:0], ~firstSample};
      if (ctl.commitRx)       rxByte <= rxShift;
    end
  end

  // Line drive: first half carries the inverse of the symbol, second half the symbol
  assign symBit  = ctl.useAckSym ? ctl.ackSym : txShift[DATA_BITS-1];
  assign lineOe  = ctl.driveOn;
  assign lineOut = ctl.driveOn ? (qIdx[1] ? symBit : ~symBit) : 1'b1;

  assign stat.qTick       = qTick;
  assign stat.qIdx        = qIdx;
  assign stat.lastBit     = (bitIdx == BIT_W'(DATA_BITS - 1));
  assign stat.pollLast    = (pollCnt == POLL_W'(POLL_LIMIT - 1));
  assign stat.firstSample = firstSample;
  assign stat.lineNow     = lineNow;

  AST_QLEN_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |-> (qLen >= Q_FLOOR));  // R9
  AST_QLEN_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |=> $stable(qLen));  // R9
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < POLL_W'(POLL_LIMIT));  // R6
  AST_RX_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commitRx |=> $stable(rxByte));  // R3

endmodule

// File: rtl/swire_ctrl.sv
module swire_ctrl
  import swire_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    opValid,
  input  logic    opRead,
  input  logic    moreBytes,
  input  logic    noSak,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    busy,
  output logic    done,
  output logic    err
);

  phase_e phase, phaseNx;
  logic   modeRead, modeMore, modeNoSak;
  logic   finish, finishErr;
  logic   replySeen;

  assign replySeen = modeNoSak ? stat.lineNow : ~stat.lineNow;

  always_comb begin
    ctl       = '0;
    phaseNx   = phase;
    finish    = 1'b0;
    finishErr = 1'b0;
    ctl.run   = (phase != PH_IDLE);
    case (phase)
      PH_IDLE: begin
        if (opValid) begin
          ctl.start = 1'b1;
          phaseNx   = PH_DATA;
        end
      end
      PH_DATA: begin
        ctl.driveOn = ~modeRead;
        if (stat.qTick) begin
          if (modeRead && stat.qIdx == 2'd0) ctl.takeFirst = 1'b1;
          if (modeRead && stat.qIdx == 2'd2) begin
            if (stat.firstSample == stat.lineNow) begin
              finish    = 1'b1;
              finishErr = 1'b1;
            end else begin
              ctl.takeBit = 1'b1;
            end
          end
          if (stat.qIdx == 2'd3) begin
            ctl.bitEnd = 1'b1;
            if (stat.lastBit) phaseNx = PH_ACKOUT;
          end
        end
      end
      PH_ACKOUT: begin
        ctl.driveOn   = 1'b1;
        ctl.useAckSym = 1'b1;
        ctl.ackSym    = modeMore;
        if (stat.qTick && stat.qIdx == 2'd3) phaseNx = PH_ACKWAIT;
      end
      PH_ACKWAIT: begin
        if (stat.qTick) begin
          if (replySeen) begin
            ctl.clrQuarter = 1'b1;
            phaseNx        = PH_ACKHOLD;
          end else if (stat.pollLast) begin
            finish    = 1'b1;
            finishErr = 1'b1;
          end else begin
            ctl.pollInc = 1'b1;
          end
        end
      end
      PH_ACKHOLD: begin
        if (stat.qTick && stat.qIdx == 2'd3) begin
          finish = 1'b1;
          if (!modeNoSak && !stat.lineNow) finishErr = 1'b1;
          else                             ctl.commitRx = modeRead;
        end
      end
      default: phaseNx = PH_IDLE;
    endcase
    if (finish) phaseNx = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      modeRead  <= 1'b0;
      modeMore  <= 1'b0;
      modeNoSak <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      phase <= phaseNx;
      done  <= finish;
      if (ctl.start) begin
        modeRead  <= opRead;
        modeMore  <= moreBytes;
        modeNoSak <= noSak;
        err       <= 1'b0;
      end else if (finish) begin
        err <= finishErr;
      end
    end
  end

  assign busy = (phase != PH_IDLE);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R10
  AST_ERR_CLEAR_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !err);  // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> done);  // R10
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rstN)
    (busy && opValid) |-> !ctl.start);  // R11

endmodule

// File: rtl/swire_bit_engine.sv
module swire_bit_engine
  import swire_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int QUARTER_W   = 16,
  parameter int MIN_QUARTER = 4,
  parameter int POLL_LIMIT  = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [QUARTER_W-1:0] quarterTicks,
  input  logic                 opValid,
  input  logic                 opRead,
  input  logic                 moreBytes,
  input  logic                 noSak,
  input  logic [DATA_BITS-1:0] txByte,
  input  logic                 lineIn,
  output logic                 lineOe,
  output logic                 lineOut,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic [DATA_BITS-1:0] rxByte
);

  dpCtrl_t ctl;
  dpStat_t stat;

  swire_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .opRead    (opRead),
    .moreBytes (moreBytes),
    .noSak     (noSak),
    .stat      (stat),
    .ctl       (ctl),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

  swire_datapath #(
    .DATA_BITS   (DATA_BITS),
    .QUARTER_W   (QUARTER_W),
    .MIN_QUARTER (MIN_QUARTER),
    .POLL_LIMIT  (POLL_LIMIT),
    .SYNC_STAGES (SYNC_STAGES)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .quarterTicks (quarterTicks),
    .txByte       (txByte),
    .ctl          (ctl),
    .lineIn       (lineIn),
    .stat         (stat),
    .lineOe       (lineOe),
    .lineOut      (lineOut),
    .rxByte       (rxByte)
  );

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !lineOe);  // R11

endmodule

// File: tb/sim_swire_bit_engine.sv
module sim_swire_bit_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] quarterTicks;
  logic        opValid, opRead, moreBytes, noSak;
  logic [7:0]  txByte;
  logic        slaveLow;
  logic        lineIn;
  logic        lineOe, lineOut, busy, done, err;
  logic [7:0]  rxByte;

  always #10 clk = ~clk;  // 50 MHz

  // Wired line: pull-up, master drive, slave pull-down
  assign lineIn = (lineOe ? lineOut : 1'b1) & ~slaveLow;

  swire_bit_engine u0 (
    .clk(clk), .rstN(rstN), .quarterTicks(quarterTicks), .opValid(opValid),
    .opRead(opRead), .moreBytes(moreBytes), .noSak(noSak), .txByte(txByte),
    .lineIn(lineIn), .lineOe(lineOe), .lineOut(lineOut), .busy(busy),
    .done(done), .err(err), .rxByte(rxByte)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFails = 0;
  int doneCnt = 0;
  logic [7:0] rxModel = 8'h00;
  bit finished = 0;

  typedef struct {
    bit         errExp;
    logic [7:0] rxExp;
    int         cycExp;
    string      req;
  } exp_t;
  exp_t expQ[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected results when done appears
  bit prevDone = 0;
  always @(negedge clk) begin
    if (rstN && prevDone) check(!done, "R10", "done longer than one cycle", done, 0);
    prevDone = done;
    if (rstN && done) begin
      doneCnt++;
      if (expQ.size() == 0) begin
        check(0, "R10", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(err == e.errExp, e.req, "err at done", err, e.errExp);
        check(cyc == e.cycExp, e.req, "done cycle", cyc, e.cycExp);
        check(rxByte == e.rxExp, "R3", "rxByte at done", rxByte, e.rxExp);
      end
    end
  end

  // Driver + slave model for one byte request
  // mode 0: slave low from poll d, releases 2 quarters after being seen
  // mode 1: slave never answers
  // mode 2: slave low from poll d and stays low
  // mode 3: slave holds line low for d quarters, then releases
  task automatic runOp(input string req, input bit rd, input logic [7:0] tx,
                       input bit more, input bit nsak, input logic [7:0] slv,
                       input int errBit, input int mode, input int d,
                       input int qSet, input bit poke);
    int q, off, A, startCnt, b, ph, w, wStart;
    bit errE, first, bv;
    logic [7:0] capByte;
    exp_t e;
    q = (qSet < 4) ? 4 : qSet;
    wStart = 36 * q;
    if (rd && errBit >= 0) begin
      errE = 1; off = errBit * 4 * q + 3 * q;
    end else begin
      case (mode)
        0: begin errE = 0; off = (41 + d) * q; end
        1: begin errE = 1; off = 56 * q; end
        2: begin errE = 1; off = (41 + d) * q; end
        default: begin
          if (d < 20) begin errE = 0; off = (41 + d) * q; end
          else        begin errE = 1; off = 56 * q; end
        end
      endcase
    end
    if (rd && !errE) rxModel = slv;
    capByte = 8'h00;
    first = 0;
    @(negedge clk);
    quarterTicks = 16'(qSet); opRead = rd; txByte = tx;
    moreBytes = more; noSak = nsak; opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    A = cyc;
    startCnt = doneCnt;
    e.errExp = errE; e.rxExp = rxModel; e.cycExp = A + off; e.req = req;
    expQ.push_back(e);
    check(busy == 1'b1, "R2", "busy after accept", busy, 1);
    check(err == 1'b0, "R10", "err cleared on accept", err, 0);
    for (int r = 0; r < 80 * q; r++) begin
      if (r > 0) @(negedge clk);
      #1;
      if (doneCnt != startCnt) break;
      if (r < 32 * q) begin
        b  = r / (4 * q);
        ph = r % (4 * q);
        bv = rd ? slv[7-b] : tx[7-b];
        if (rd) begin
          if (ph == 0)     slaveLow = (b == errBit) ? 1'b1 : bv;
          if (ph == 2 * q) slaveLow = (b == errBit) ? 1'b1 : ~bv;
          if (ph == q / 2) check(lineOe == 1'b0, "R3", "line released in read", lineOe, 0);
        end else begin
          if (ph == q / 2) begin
            check(lineOe == 1'b1, "R1", "line driven in write", lineOe, 1);
            first = lineOut;
          end
          if (ph == 2 * q + q / 2) begin
            check(first != lineOut, "R1", "mid-bit edge", lineOut, ~first);
            capByte[7-b] = ~first & lineOut;
          end
        end
      end
      if (r == 32 * q) begin
        slaveLow = 1'b0;
        if (!rd) check(capByte == tx, "R2", "byte seen on line", capByte, tx);
      end
      if (r == 32 * q + q / 2)
        check(lineOe && (lineOut == ~more), "R5", "ack first half", lineOut, ~more);
      if (r == 34 * q + q / 2)
        check(lineOe && (lineOut == more), "R5", "ack second half", lineOut, more);
      if (r >= wStart) begin
        w = r - wStart;
        case (mode)
          0: begin
            if (w == d * q)       slaveLow = 1'b1;
            if (w == (d + 3) * q) slaveLow = 1'b0;
          end
          2: if (w == d * q) slaveLow = 1'b1;
          3: begin
            if (w == 0 && d > 0) slaveLow = 1'b1;
            if (w == d * q)      slaveLow = 1'b0;
          end
          default: ;
        endcase
      end
      if (poke && r == 5) begin opValid = 1'b1; txByte = ~tx; end
      if (poke && r == 6) opValid = 1'b0;
      if (poke && r == 7) quarterTicks = 16'd9;
    end
    slaveLow = 1'b0;
    check(doneCnt != startCnt, req, "request completed", doneCnt - startCnt, 1);
    @(negedge clk);
    check(lineOe == 1'b0 && busy == 1'b0, "R11", "released and idle after done",
          {lineOe, busy}, 0);
  endtask

  initial begin
    quarterTicks = 16'd5; opValid = 0; opRead = 0; moreBytes = 0; noSak = 0;
    txByte = 8'h00; slaveLow = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(lineOe == 0 && busy == 0 && done == 0 && err == 0 && rxByte == 0,
          "R12", "reset outputs", {lineOe, busy, done, err, rxByte}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(lineOe == 0, "R11", "idle line released", lineOe, 0);

    runOp("R6", 0, 8'hA5, 1, 0, 8'h00, -1, 0, 2, 5, 0);   // write, MAK, SAK at poll 2
    runOp("R8", 0, 8'h3C, 0, 1, 8'h00, -1, 3, 0, 5, 0);   // write, NoMAK, NoSAK immediate
    runOp("R3", 1, 8'h00, 0, 0, 8'h96, -1, 0, 0, 5, 0);   // read 0x96
    runOp("R4", 1, 8'h00, 1, 0, 8'h5A, 3, 0, 0, 5, 0);    // equal samples at bit 3
    repeat (10) @(negedge clk);
    check(err == 1'b1, "R10", "err held after failure", err, 1);
    runOp("R6", 0, 8'h01, 1, 0, 8'h00, -1, 1, 0, 5, 0);   // no slave reply: timeout
    runOp("R7", 0, 8'h80, 0, 0, 8'h00, -1, 2, 1, 5, 0);   // reply stuck low
    runOp("R8", 0, 8'hFF, 1, 1, 8'h00, -1, 3, 25, 5, 0);  // line held low: timeout
    runOp("R8", 1, 8'h00, 0, 1, 8'h00, -1, 3, 4, 5, 0);   // read, line high after 4 quarters
    runOp("R9", 0, 8'h69, 1, 0, 8'h00, -1, 0, 19, 2, 1);  // floor of 4, late change, busy request (R11), reply on last poll
    runOp("R9", 1, 8'h00, 1, 0, 8'hC3, -1, 0, 1, 0, 0);   // zero quarter length
    runOp("R4", 1, 8'h00, 0, 0, 8'hFF, 7, 0, 0, 6, 0);    // failure on last bit keeps rxByte
    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R10", "all results seen", expQ.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(0, "R10", "watchdog expired", cyc, 0);
      $display("Result: errors=%0d of %0d checks", nFails, nChecks);
      $finish;
    end
  end

endmodule